// File: doc/BRIEF.md
# Two-Wire Serial Slave Interface

This block is the target side of an open-drain two-wire serial bus of the I2C type. It runs from a fast system clock and oversamples the bus clock and data inputs through a small synchronizer. It detects Start and Stop conditions. It shifts bytes in and out one bit per bus clock pulse, most significant bit first. On the ninth clock pulse of each received byte it either pulls the data line low to acknowledge or leaves the line released.

The first byte after a Start carries a 7-bit target address and a direction bit, where 1 means read. A matching address with a write direction makes the block deliver each following byte on a one-cycle strobe. A matching address with a read direction makes the block request a byte from the user and drive its bits onto the bus. The block keeps sending bytes for as long as the bus master acknowledges them. A user busy input withholds every acknowledge while an internal write cycle is in progress.

The data line is only ever pulled low through an enable output. It is never driven high.

Top module: `tws_slave`

## Requirements
- R1: After reset, sdaPullLow, rxValid and txReq are all 0, and no byte has been delivered or requested.
- R2: A Start condition (data falls while the bus clock is high) begins address reception from any state. This includes a repeated Start in the middle of a byte, which discards the partial byte and restarts the bit count.
- R3: The address byte is received MSB first: seven address bits, then the direction bit. If the address equals DEV_ADDR and busyIn is 0, the block holds the data line low through the whole high period of the ninth clock.
- R4: If the address does not equal DEV_ADDR, the block never pulls the data line and raises neither rxValid nor txReq until the next Start or Stop.
- R5: In a write transfer, each data byte (MSB first) that arrives while busyIn is 0 is acknowledged on its ninth clock. It is also presented on rxData with a single-cycle rxValid pulse.
- R6: If busyIn is 1 when an address or write byte completes, that byte is not acknowledged and not delivered. All further traffic is then ignored until the next Start or Stop.
- R7: In a read transfer, txReq pulses once for every byte to be sent. Each bit of txData is placed on the bus MSB first: the line is pulled low exactly when the bit is 0, and it stays stable for the whole high period of the bus clock. txData is taken at the bus clock fall that ends the acknowledge clock following txReq.
- R8: If the master acknowledges a read byte (data low on the ninth clock), the next byte is requested and sent. If it does not, the block releases the data line and drives nothing more until the next Start or Stop.
- R9: A Stop condition (data rises while the bus clock is high) returns the block to idle with the data line released. Clock pulses that follow without a Start are ignored.
- R10: sdaPullLow changes only while the synchronized bus clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaPullLow | output | 1 | When 1, the pad pulls the data line low; when 0, the line is released |
| busyIn | input | 1 | User write cycle in progress; suppresses acknowledges |
| rxValid | output | 1 | One-cycle strobe: a write byte was accepted |
| rxData | output | DATA_W | The accepted write byte, valid with rxValid |
| txReq | output | 1 | One-cycle strobe: present the next read byte on txData |
| txData | input | DATA_W | Byte to transmit |

## Verification
A control state that disagrees with the bus position shows up on the data line within one bus bit. The block either acknowledges when it should stay silent, or it drives read bits during the master's acknowledge slot. A bad bit counter shifts every later byte by one position, so rxData or the read byte seen by the master is wrong on the first byte. A wrong busy or mismatch decision shows on the very next ninth clock as a missing or extra acknowledge, and also as a change in the number of rxValid or txReq pulses.

// File: rtl/tws_pkg.sv
package tws_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_RD_NEXT,
    ST_SKIP
  } tws_state_e;

  // strobes from control to datapath, valid for one system clock
  typedef struct packed {
    logic clrCnt;
    logic countBit;
    logic shiftIn;
    logic shiftOut;
    logic loadTx;
    logic driveAck;
    logic dropSda;
    logic rxStrobe;
    logic reqTx;
  } tws_ctl_t;

endpackage

// File: rtl/tws_datapath.sv
module tws_datapath
  import tws_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h52,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [DATA_W-1:0] txData,
  input  tws_ctl_t          ctl,
  output logic              sclSync,
  output logic              sdaSync,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic              byteDone,
  output logic              addrMatch,
  output logic              rwBit,
  output logic [CNT_W-1:0]  bitCnt,
  output logic              sdaPullLow,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxData,
  output logic              txReq
);

  localparam int LINES = 2;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_W);

  logic [LINES-1:0] rawLine;
  logic [LINES-1:0] syncLine;
  logic [LINES-1:0] prevLine;
  logic [DATA_W-1:0] shReg;

  assign rawLine = {sdaIn, sclIn};

  // one synchronizer chain per bus line, plus a delayed copy for edges
  for (genvar g = 0; g < LINES; g++) begin : gSync
    logic [SYNC_STAGES:0] pipe;
    always_ff @(posedge clk) begin
      if (!rstN) pipe <= '1;
      else       pipe <= {pipe[SYNC_STAGES-1:0], rawLine[g]};
    end
    assign syncLine[g] = pipe[SYNC_STAGES-1];
    assign prevLine[g] = pipe[SYNC_STAGES];
  end

  logic sclPrev, sdaPrev;
  assign sclSync = syncLine[0];
  assign sdaSync = syncLine[1];
  assign sclPrev = prevLine[0];
  assign sdaPrev = prevLine[1];

  assign sclRise  = sclSync & ~sclPrev;
  assign sclFall  = ~sclSync & sclPrev;
  assign startDet = sclSync & sclPrev & sdaPrev & ~sdaSync;
  assign stopDet  = sclSync & sclPrev & ~sdaPrev & sdaSync;

  assign byteDone  = (bitCnt == FULL_CNT);
  assign addrMatch = (shReg[DATA_W-1 -: ADDR_W] == DEV_ADDR);
  assign rwBit     = shReg[0];

  always_ff @(posedge clk) begin
    if (!rstN)             bitCnt <= '0;
    else if (ctl.clrCnt)   bitCnt <= '0;
    else if (ctl.countBit) bitCnt <= bitCnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)             shReg <= '0;
    else if (ctl.loadTx)   shReg <= txData;
    else if (ctl.shiftIn)  shReg <= {shReg[DATA_W-2:0], sdaSync};
    else if (ctl.shiftOut) shReg <= {shReg[DATA_W-2:0], 1'b0};
  end

  // open-drain enable: 1 pulls the line low
  always_ff @(posedge clk) begin
    if (!rstN)             sdaPullLow <= 1'b0;
    else if (ctl.loadTx)   sdaPullLow <= ~txData[DATA_W-1];
    else if (ctl.shiftOut) sdaPullLow <= ~shReg[DATA_W-2];
    else if (ctl.driveAck) sdaPullLow <= 1'b1;
    else if (ctl.dropSda)  sdaPullLow <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxValid <= 1'b0;
      rxData  <= '0;
      txReq   <= 1'b0;
    end else begin
      rxValid <= ctl.rxStrobe;
      txReq   <= ctl.reqTx;
      if (ctl.rxStrobe) rxData <= shReg;
    end
  end

endmodule

// File: rtl/tws_control.sv
module tws_control
  import tws_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     sclRise,
  input  logic     sclFall,
  input  logic     sdaSync,
  input  logic     startDet,
  input  logic     stopDet,
  input  logic     byteDone,
  input  logic     addrMatch,
  input  logic     rwBit,
  input  logic     busyIn,
  output tws_ctl_t ctl
);

  tws_state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    ctl       = '0;
    stateNext = state;
    if (stopDet) begin
      ctl.dropSda = 1'b1;
      ctl.clrCnt  = 1'b1;
      stateNext   = ST_IDLE;
    end else if (startDet) begin
      ctl.dropSda = 1'b1;
      ctl.clrCnt  = 1'b1;
      stateNext   = ST_ADDR;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (sclRise && !byteDone) begin
            ctl.shiftIn  = 1'b1;
            ctl.countBit = 1'b1;
          end else if (sclFall && byteDone) begin
            if (addrMatch && !busyIn) begin
              ctl.driveAck = 1'b1;
              ctl.reqTx    = rwBit;
              stateNext    = ST_ADDR_ACK;
            end else begin
              stateNext = ST_SKIP;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            ctl.clrCnt = 1'b1;
            if (rwBit) begin
              ctl.loadTx = 1'b1;
              stateNext  = ST_RD;
            end else begin
              ctl.dropSda = 1'b1;
              stateNext   = ST_WR;
            end
          end
        end
        ST_WR: begin
          if (sclRise && !byteDone) begin
            ctl.shiftIn  = 1'b1;
            ctl.countBit = 1'b1;
          end else if (sclFall && byteDone) begin
            if (!busyIn) begin
              ctl.driveAck = 1'b1;
              ctl.rxStrobe = 1'b1;
              stateNext    = ST_WR_ACK;
            end else begin
              stateNext = ST_SKIP;
            end
          end
        end
        ST_WR_ACK: begin
          if (sclFall) begin
            ctl.dropSda = 1'b1;
            ctl.clrCnt  = 1'b1;
            stateNext   = ST_WR;
          end
        end
        ST_RD: begin
          if (sclRise && !byteDone) begin
            ctl.countBit = 1'b1;
          end else if (sclFall) begin
            if (byteDone) begin
              ctl.dropSda = 1'b1;
              stateNext   = ST_RD_ACK;
            end else begin
              ctl.shiftOut = 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (sclRise) begin
            if (!sdaSync) begin
              ctl.reqTx = 1'b1;
              stateNext = ST_RD_NEXT;
            end else begin
              stateNext = ST_SKIP;
            end
          end
        end
        ST_RD_NEXT: begin
          if (sclFall) begin
            ctl.loadTx = 1'b1;
            ctl.clrCnt = 1'b1;
            stateNext  = ST_RD;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/tws_slave.sv
module tws_slave
  import tws_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h52,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaPullLow,
  input  logic              busyIn,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxData,
  output logic              txReq,
  input  logic [DATA_W-1:0] txData
);

  localparam int CNT_W = $clog2(DATA_W + 1);

  tws_ctl_t         ctl;
  logic             sclSync, sdaSync, sclRise, sclFall;
  logic             startDet, stopDet, byteDone, addrMatch, rwBit;
  logic [CNT_W-1:0] bitCnt;

  tws_datapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR),
    .SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .txData(txData),
    .ctl(ctl), .sclSync(sclSync), .sdaSync(sdaSync), .sclRise(sclRise),
    .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .byteDone(byteDone), .addrMatch(addrMatch), .rwBit(rwBit),
    .bitCnt(bitCnt), .sdaPullLow(sdaPullLow), .rxValid(rxValid),
    .rxData(rxData), .txReq(txReq)
  );

  tws_control uCtrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .sdaSync(sdaSync), .startDet(startDet), .stopDet(stopDet),
    .byteDone(byteDone), .addrMatch(addrMatch), .rwBit(rwBit),
    .busyIn(busyIn), .ctl(ctl)
  );

endmodule

// File: rtl/tws_checker.sv
module tws_checker #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             sclSync,
  input logic             startDet,
  input logic             stopDet,
  input logic [CNT_W-1:0] bitCnt,
  input logic             sdaPullLow,
  input logic             rxValid,
  input logic             txReq,
  input logic             busyIn
);

  AST_START_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (bitCnt == '0)); // R2

  AST_RX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid); // R5

  AST_NO_RX_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> !$past(busyIn)); // R6

  AST_TXREQ_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    txReq |=> !txReq); // R7

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaPullLow); // R9

  AST_PULL_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (sdaPullLow != $past(sdaPullLow)) |-> !sclSync); // R10

endmodule

bind tws_slave tws_checker #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .sclSync(sclSync), .startDet(startDet),
  .stopDet(stopDet), .bitCnt(bitCnt), .sdaPullLow(sdaPullLow),
  .rxValid(rxValid), .txReq(txReq), .busyIn(busyIn)
);

// File: tb/tb_tws_slave.sv
module tb_tws_slave;

  localparam int Q = 10;
  localparam logic [6:0] DEV = 7'h52;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic busyIn = 1'b0;
  logic [7:0] txData = 8'h00;
  logic sdaPullLow, rxValid, txReq;
  logic [7:0] rxData;
  logic sdaBus;

  int checks = 0;
  int errors = 0;
  int rxCnt = 0;
  int txCnt = 0;
  logic [7:0] lastRx = 8'h00;
  bit finished = 0;

  always #4 clk = ~clk;

  assign sdaBus = sdaM & ~sdaPullLow;

  tws_slave #(.DEV_ADDR(DEV)) dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .sdaPullLow(sdaPullLow), .busyIn(busyIn), .rxValid(rxValid),
    .rxData(rxData), .txReq(txReq), .txData(txData)
  );

  always @(negedge clk) begin
    if (rxValid) begin
      rxCnt  = rxCnt + 1;
      lastRx = rxData;
    end
    if (txReq) txCnt = txCnt + 1;
  end

  function automatic logic [7:0] genTx(input int k);
    logic [7:0] v;
    v = 8'(k * 91 + 60);
    return v ^ 8'(k << 3);
  endfunction

  function automatic bit expAck(input logic [6:0] a, input bit busy);
    return (a == DEV) && !busy;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bitCycle(input logic b, output logic s1, output logic s2);
    waitQ(); sdaM = b;
    waitQ(); sclM = 1'b1;
    waitQ(); s1 = sdaBus;
    waitQ(); s2 = sdaBus; sclM = 1'b0;
  endtask

  task automatic startCond();
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    sclM = 1'b0;
  endtask

  task automatic stopCond();
    waitQ(); sdaM = 1'b0;
    waitQ(); sclM = 1'b1;
    waitQ(); sdaM = 1'b1;
    waitQ();
  endtask

  task automatic writeByte(input logic [7:0] b, output bit acked, output bit anyLow);
    logic s1, s2;
    anyLow = 0;
    for (int i = 7; i >= 0; i--) begin
      bitCycle(b[i], s1, s2);
      if (b[i] && (!s1 || !s2)) anyLow = 1;
    end
    bitCycle(1'b1, s1, s2);
    acked = !s1 && !s2;
  endtask

  task automatic readByte(input bit mAck, input logic [7:0] nextTx,
                          output logic [7:0] v, output bit stable);
    logic s1, s2;
    stable = 1;
    for (int i = 7; i >= 0; i--) begin
      bitCycle(1'b1, s1, s2);
      v[i] = s1;
      if (s1 != s2) stable = 0;
    end
    txData = nextTx;
    bitCycle(!mAck, s1, s2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit acked, anyLow, stable;
    logic [7:0] v;
    int rx0, tx0;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    check(sdaPullLow == 0 && rxValid == 0 && txReq == 0, "R1", "outputs after reset",
          {sdaPullLow, rxValid, txReq}, 0);
    check(rxCnt == 0 && txCnt == 0, "R1", "no strobes after reset", rxCnt + txCnt, 0);

    // R3 R5 directed write
    rx0 = rxCnt;
    startCond();
    writeByte({DEV, 1'b0}, acked, anyLow);
    check(acked, "R3", "address ack", acked, 1);
    writeByte(8'hA5, acked, anyLow);
    check(acked, "R5", "data ack", acked, 1);
    check(rxCnt == rx0 + 1 && lastRx == 8'hA5, "R5", "rxData", lastRx, 8'hA5);
    writeByte(8'h00, acked, anyLow);
    check(acked && lastRx == 8'h00 && rxCnt == rx0 + 2, "R5", "second byte", lastRx, 0);
    stopCond();

    // R4 mismatch
    rx0 = rxCnt; tx0 = txCnt;
    startCond();
    writeByte({DEV ^ 7'h01, 1'b0}, acked, anyLow);
    check(!acked, "R4", "mismatch no ack", acked, 0);
    writeByte(8'hFF, acked, anyLow);
    check(!acked && !anyLow, "R4", "line untouched after mismatch", anyLow, 0);
    check(rxCnt == rx0 && txCnt == tx0, "R4", "no strobes on mismatch", rxCnt - rx0, 0);
    stopCond();

    // R6 busy at address
    busyIn = 1'b1;
    rx0 = rxCnt;
    startCond();
    writeByte({DEV, 1'b0}, acked, anyLow);
    check(!acked, "R6", "busy address no ack", acked, 0);
    stopCond();
    busyIn = 1'b0;

    // R6 busy on a data byte, then stays ignored
    startCond();
    writeByte({DEV, 1'b0}, acked, anyLow);
    writeByte(8'h3C, acked, anyLow);
    check(acked && rxCnt == rx0 + 1, "R6", "ack before busy", rxCnt - rx0, 1);
    busyIn = 1'b1;
    writeByte(8'hC3, acked, anyLow);
    check(!acked && rxCnt == rx0 + 1, "R6", "busy data byte dropped", rxCnt - rx0, 1);
    busyIn = 1'b0;
    writeByte(8'h77, acked, anyLow);
    check(!acked && rxCnt == rx0 + 1, "R6", "ignored after busy nack", rxCnt - rx0, 1);
    stopCond();

    // R7 R8 read, three bytes
    tx0 = txCnt;
    txData = genTx(0);
    startCond();
    writeByte({DEV, 1'b1}, acked, anyLow);
    check(acked, "R3", "read address ack", acked, 1);
    for (int i = 0; i < 3; i++) begin
      readByte(i < 2, genTx(i + 1), v, stable);
      check(v == genTx(i), "R7", "read byte value", v, genTx(i));
      check(stable, "R7", "bit stable while clock high", stable, 1);
    end
    check(txCnt == tx0 + 3, "R8", "one request per byte", txCnt - tx0, 3);
    readByte(0, 8'h00, v, stable);
    check(v == 8'hFF, "R8", "released after master nack", v, 8'hFF);
    check(txCnt == tx0 + 3, "R8", "no request after nack", txCnt - tx0, 3);
    stopCond();

    // R2 repeated start mid byte
    rx0 = rxCnt;
    startCond();
    writeByte({DEV, 1'b0}, acked, anyLow);
    begin
      logic s1, s2;
      bitCycle(1'b1, s1, s2);
      bitCycle(1'b0, s1, s2);
      bitCycle(1'b1, s1, s2);
    end
    startCond();
    writeByte({DEV, 1'b0}, acked, anyLow);
    check(acked, "R2", "address after repeated start", acked, 1);
    writeByte(8'h5A, acked, anyLow);
    check(acked && lastRx == 8'h5A && rxCnt == rx0 + 1, "R2", "byte after repeated start",
          lastRx, 8'h5A);
    stopCond();

    // R9 clocks after stop are ignored
    rx0 = rxCnt;
    writeByte({DEV, 1'b0}, acked, anyLow);
    check(!acked && sdaPullLow == 0, "R9", "no ack without start", acked, 0);
    writeByte(8'h81, acked, anyLow);
    check(!acked && rxCnt == rx0, "R9", "no delivery without start", rxCnt - rx0, 0);
    stopCond();

    // random transactions (R3 R4 R5 R6 R7)
    for (int t = 0; t < 24; t++) begin
      logic [6:0] a;
      bit rw, busy, ea;
      int n;
      logic [7:0] d;
      a    = ($urandom % 2) ? DEV : (DEV ^ 7'($urandom % 127 + 1));
      rw   = $urandom % 2;
      busy = ($urandom % 4) == 0;
      n    = 1 + $urandom % 3;
      ea   = expAck(a, busy);
      busyIn = busy;
      rx0 = rxCnt; tx0 = txCnt;
      txData = genTx(100 + t * 4);
      startCond();
      writeByte({a, rw}, acked, anyLow);
      check(acked == ea, "R3", "random address ack", acked, ea);
      if (!rw) begin
        for (int i = 0; i < n; i++) begin
          d = 8'($urandom);
          writeByte(d, acked, anyLow);
          check(acked == ea, "R5", "random write ack", acked, ea);
          if (ea) check(lastRx == d, "R5", "random write data", lastRx, d);
        end
        check(rxCnt - rx0 == (ea ? n : 0), "R6", "random delivery count", rxCnt - rx0,
              ea ? n : 0);
      end else if (ea) begin
        for (int i = 0; i < n; i++) begin
          readByte(i < n - 1, genTx(100 + t * 4 + i + 1), v, stable);
          check(v == genTx(100 + t * 4 + i), "R7", "random read data", v,
                genTx(100 + t * 4 + i));
        end
        check(txCnt - tx0 == n, "R7", "random request count", txCnt - tx0, n);
      end else begin
        readByte(0, 8'h00, v, stable);
        check(v == 8'hFF && txCnt == tx0, "R4", "silent read", v, 8'hFF);
      end
      stopCond();
      busyIn = 1'b0;
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule